// File: doc/BRIEF.md
# Cascadable Active-Low Priority Encoder

This block is a wide priority encoder made of a chain of narrow encoder slices. Each slice watches a small group of request lines and names the highest-numbered line that is being pulled low. Every slice also takes an enable from the slice above it. A slice passes the enable on to the slice below it only when it is enabled and sees no request of its own. Because of this chain, exactly one slice at most can claim the request. The assembly then merges the slices into a single binary code for the whole request vector.

Every pin of the block uses active-low signalling. This covers the requests, the code, the enable in, the enable out and the group-valid flag. An idle or disabled slice drives its code to all ones, which is logic value 0. Because of that, the top level can merge the low code bits from all slices with a plain AND. It takes the high code bits from the identity of the slice that claimed the request. The default build has four slices of eight lines, giving 32 requests and a 5-bit code. The design is purely combinational: it has no clock, no state and no handshake. The slice is also a standalone module, so other widths can be assembled from it.

Top module: `pe_cascade`

## Requirements
- R1: A request line is asserted when it is driven to 0. When enabled, `code_n` carries the bitwise inverse of the index of the highest-numbered asserted request. For example, request 5 alone gives `code_n` = 5'b11010.
- R2: Line 31 has the highest priority and line 0 the lowest. Asserted requests below the highest one have no effect on `code_n`.
- R3: When `en_in_n` is 1, all outputs are inactive whatever the requests are: `code_n` is all ones, `gs_n` is 1 and `en_out_n` is 1.
- R4: `gs_n` is 0 exactly when `en_in_n` is 0 and at least one request is asserted.
- R5: `en_out_n` is 0 exactly when `en_in_n` is 0 and no request is asserted.
- R6: When enabled with no request asserted, `code_n` is all ones.
- R7: The upper two bits of the inverted code give the group of eight that holds the winning request. Lines 31..24 give group 3 and lines 7..0 give group 0. The lower three bits give the position of the winner inside its group.
- R8: A single slice (`pe_lane`, eight lines) follows the rules of R1 to R6 on its own, with a 3-bit code and line 7 highest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| req_n | input | 32 | Request lines, active-low |
| en_in_n | input | 1 | Chain enable input, active-low |
| code_n | output | 5 | Index of highest asserted request, inverted |
| gs_n | output | 1 | Some request claimed, active-low |
| en_out_n | output | 1 | Enable to the next lower-priority encoder, active-low |

## Verification
The bench builds the top with its defaults: four slices of eight lines. This puts every slice boundary within reach of single-hot sweeps, and it also exercises the enable hand-off from slice to slice under random multi-hot patterns. A separate eight-line slice is built beside the top and driven with all 256 request patterns at both enable levels. Together these cover the slice's truth table exhaustively.

// File: rtl/pe_pkg.sv
`timescale 1ns/1ps
package pe_pkg;
  localparam int unsigned LANE_W_DEF = 8;
  localparam int unsigned LANES_DEF  = 4;
endpackage

// File: rtl/pe_scan.sv
`timescale 1ns/1ps
module pe_scan #(
  parameter int unsigned W  = pe_pkg::LANE_W_DEF,
  localparam int unsigned IW = $clog2(W)
) (
  input  logic [W-1:0]  act,
  output logic [IW-1:0] top_idx,
  output logic          any
);
  // Later iterations override earlier ones, so the highest set bit wins.
  always_comb begin
    top_idx = '0;
    for (int i = 0; i < W; i++) begin
      if (act[i]) top_idx = IW'(i);
    end
  end

  assign any = |act;
endmodule

// File: rtl/pe_lane.sv
`timescale 1ns/1ps
module pe_lane #(
  parameter int unsigned W  = pe_pkg::LANE_W_DEF,
  localparam int unsigned IW = $clog2(W)
) (
  input  logic [W-1:0]  req_n,
  input  logic          en_in_n,
  output logic [IW-1:0] code_n,
  output logic          gs_n,
  output logic          en_out_n
);
  logic [IW-1:0] idx;
  logic          any;
  logic          en;
  logic          hit;

  pe_scan #(.W(W)) u_scan (
    .act     (~req_n),
    .top_idx (idx),
    .any     (any)
  );

  assign en       = ~en_in_n;
  assign hit      = en & any;
  assign gs_n     = ~hit;
  assign en_out_n = ~(en & ~any);
  assign code_n   = hit ? ~idx : '1;
endmodule

// File: rtl/pe_merge.sv
`timescale 1ns/1ps
module pe_merge #(
  parameter int unsigned LANES = pe_pkg::LANES_DEF,
  parameter int unsigned CW    = 3,
  localparam int unsigned UW   = $clog2(LANES)
) (
  input  logic [LANES-1:0]    lane_gs_n,
  input  logic [LANES*CW-1:0] lane_code_n,
  output logic [UW+CW-1:0]    code_n,
  output logic                gs_n
);
  logic [UW-1:0] up;
  logic [CW-1:0] lo_n;

  // Only one lane can claim at a time, so OR-ing lane numbers is exact.
  always_comb begin
    up = '0;
    for (int k = 0; k < LANES; k++) begin
      if (!lane_gs_n[k]) up = up | UW'(k);
    end
  end

  // Idle lanes drive all ones, so AND keeps only the claiming lane's code.
  always_comb begin
    lo_n = '1;
    for (int k = 0; k < LANES; k++) begin
      lo_n = lo_n & lane_code_n[k*CW +: CW];
    end
  end

  assign code_n = {~up, lo_n};
  assign gs_n   = &lane_gs_n;
endmodule

// File: rtl/pe_cascade.sv
`timescale 1ns/1ps
module pe_cascade #(
  parameter int unsigned LANE_W = pe_pkg::LANE_W_DEF,
  parameter int unsigned LANES  = pe_pkg::LANES_DEF,
  localparam int unsigned N     = LANE_W * LANES,
  localparam int unsigned CW    = $clog2(LANE_W),
  localparam int unsigned OW    = $clog2(N)
) (
  input  logic [N-1:0]  req_n,
  input  logic          en_in_n,
  output logic [OW-1:0] code_n,
  output logic          gs_n,
  output logic          en_out_n
);
  logic [LANES:0]       chain_n;
  logic [LANES-1:0]     lane_gs_n;
  logic [LANES*CW-1:0]  lane_code_n;

  assign chain_n[LANES] = en_in_n;

  // Highest lane is first in the enable chain.
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    pe_lane #(.W(LANE_W)) u_lane (
      .req_n    (req_n[k*LANE_W +: LANE_W]),
      .en_in_n  (chain_n[k+1]),
      .code_n   (lane_code_n[k*CW +: CW]),
      .gs_n     (lane_gs_n[k]),
      .en_out_n (chain_n[k])
    );
  end

  pe_merge #(.LANES(LANES), .CW(CW)) u_merge (
    .lane_gs_n   (lane_gs_n),
    .lane_code_n (lane_code_n),
    .code_n      (code_n),
    .gs_n        (gs_n)
  );

  assign en_out_n = chain_n[0];
endmodule

// File: rtl/pe_cascade_chk.sv
`timescale 1ns/1ps
module pe_cascade_chk #(
  parameter int unsigned N  = 32,
  parameter int unsigned OW = 5
) (
  input logic [N-1:0]  req_n,
  input logic          en_in_n,
  input logic [OW-1:0] code_n,
  input logic          gs_n,
  input logic          en_out_n
);
  logic [OW-1:0] idx;
  logic [N-1:0]  act;
  assign idx = ~code_n;
  assign act = ~req_n;

  always_comb begin
    // R3
    disabled_quiet_chk: assert (!(en_in_n && (!gs_n || !en_out_n || code_n != '1)));
    // R4
    gs_eo_excl_chk: assert (!(!gs_n && !en_out_n));
    // R5
    idle_passes_chk: assert (!(!en_in_n && act == '0 && en_out_n));
    // R6
    idle_code_chk: assert (!(gs_n && code_n != '1));
    // R1
    winner_active_chk: assert (gs_n || act[idx]);
    // R2
    nothing_above_chk: assert (gs_n || ((act >> idx) == N'(1)));
  end
endmodule

bind pe_cascade pe_cascade_chk #(.N(N), .OW(OW)) u_chk (
  .req_n    (req_n),
  .en_in_n  (en_in_n),
  .code_n   (code_n),
  .gs_n     (gs_n),
  .en_out_n (en_out_n)
);

// File: tb/sim_pe_cascade.sv
`timescale 1ns/1ps
module sim_pe_cascade;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [31:0] req_n = '1;
  logic        en_in_n = 1'b0;
  logic [4:0]  code_n;
  logic        gs_n, en_out_n;

  logic [7:0]  l_req_n = '1;
  logic        l_en_n = 1'b0;
  logic [2:0]  l_code_n;
  logic        l_gs_n, l_eo_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  pe_cascade u0 (
    .req_n(req_n), .en_in_n(en_in_n), .code_n(code_n),
    .gs_n(gs_n), .en_out_n(en_out_n)
  );

  pe_lane #(.W(8)) u1 (
    .req_n(l_req_n), .en_in_n(l_en_n), .code_n(l_code_n),
    .gs_n(l_gs_n), .en_out_n(l_eo_n)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h (req_n=%h en_n=%b)",
               tag, what, act, exp, req_n, en_in_n);
    end
  endtask

  // Behavioural reference: scan from the top line downward.
  task automatic ref_model(input int n, input logic [31:0] r_n, input logic e_n,
                           output int code, output int gs, output int eo);
    int win = -1;
    for (int i = n - 1; i >= 0; i--) begin
      if (win < 0 && r_n[i] == 1'b0) win = i;
    end
    if (e_n) begin code = (1 << $clog2(n)) - 1; gs = 1; eo = 1; end
    else if (win < 0) begin code = (1 << $clog2(n)) - 1; gs = 1; eo = 0; end
    else begin code = (~win) & ((1 << $clog2(n)) - 1); gs = 0; eo = 1; end
  endtask

  task automatic apply_top(input logic [31:0] r, input logic e, input string tag);
    int c, g, o;
    @(negedge clk);
    req_n = r; en_in_n = e;
    @(posedge clk); #1;
    ref_model(32, r, e, c, g, o);
    chk(tag, "code_n", int'(code_n), c);
    chk(tag, "gs_n", int'(gs_n), g);
    chk(tag, "en_out_n", int'(en_out_n), o);
  endtask

  task automatic apply_lane(input logic [7:0] r, input logic e);
    int c, g, o;
    @(negedge clk);
    l_req_n = r; l_en_n = e;
    @(posedge clk); #1;
    ref_model(8, {24'hFFFFFF, r}, e, c, g, o);
    chk("R8", "lane code_n", int'(l_code_n), c);
    chk("R8", "lane gs_n", int'(l_gs_n), g);
    chk("R8", "lane en_out_n", int'(l_eo_n), o);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    // R6 R5: idle after reset, enabled, nothing requested
    apply_top('1, 1'b0, "R6");
    // R1 R7: every single line, enabled
    for (int i = 0; i < 32; i++) apply_top(~(32'h1 << i), 1'b0, "R1_R7");
    // R3: every single line, disabled
    for (int i = 0; i < 32; i++) apply_top(~(32'h1 << i), 1'b1, "R3");
    // R2: all lines active -> 31 wins; lowest plus boundary pairs
    apply_top('0, 1'b0, "R2");
    apply_top(~32'h0100_0001, 1'b0, "R2");
    apply_top(~32'h0000_0180, 1'b0, "R2");
    apply_top(~32'h00FF_FF00, 1'b0, "R2");
    apply_top('0, 1'b1, "R3");
    // R4 R5 R2: random multi-hot at both enable levels
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a;
      a = $urandom & $urandom & $urandom;
      if (i % 16 == 0) a = '0;
      apply_top(~a, 1'(i % 3 == 0), "R4_R5");
    end
    // R8: standalone slice exhaustively
    for (int e = 0; e < 2; e++)
      for (int p = 0; p < 256; p++) apply_lane(8'(p), 1'(e));
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule